// File: doc/BRIEF.md
# Frame Sync Divider with Realignment

This block turns a fast output clock into a low-rate frame sync. A counter runs modulo a programmable ratio and sends out a one-cycle high pulse at the end of each frame. Left alone, the divider runs freely, and every frame holds the same number of fast-clock cycles.

The divider can be pulled into phase with an external sync reference. That reference is asynchronous to the fast clock, so it is synchronized before use. Once a realignment is armed, the next selected edge of the synchronized reference reloads the counter. The next pulse then lands a programmed number of fast-clock cycles after that edge. Reset arms one realignment automatically. After that, a rising edge on a request, taken from either a pin or a register bit, arms another. A realignment may shorten or stretch one frame. While a realignment is armed, the divide ratio changes only on a strobe.

Top module: `fsd_frame_sync`

## Requirements
- R1: The ratio register accepts only 1 or an even value from 2 to 2^19 (524288). Any other value on `div_val`, such as 7 or 524290, is ignored and the previous ratio is kept.
- R2: With no realignment taking place, `fs_out` is high for exactly one cycle in every N cycles, where N is the current ratio. Successive pulses are exactly N cycles apart.
- R3: A ratio of 1 holds `fs_out` high on every cycle.
- R4: When `align_sel` = 1, a rising edge on `align_pin` arms a realignment. When `align_sel` = 0, a rising edge on `align_reg` arms it. The request that is not selected has no effect.
- R5: When `edge_pol` = 0, a rising edge of `sync_ref` realigns. When `edge_pol` = 1, a falling edge realigns. The other edge has no effect.
- R6: `fs_out` is low during reset. Leaving reset arms a realignment without any request.
- R7: Take a `sync_ref` transition made between rising edges k-1 and k. On realignment, the first pulse is high in the cycle that follows rising edge k+2+S, where S is `skew`. Pulses then repeat every N cycles.
- R8: A `skew` value of N or more is treated as N-1.
- R9: While a realignment is armed, `div_val` is taken only on cycles where `div_valid` = 1. When no realignment is armed, it is taken on every cycle. A ratio taken in a pulse cycle sets the length of the next frame.
- R10: Each arming allows one realignment. Edges of `sync_ref` after it leave the frame phase unchanged until the block is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that is divided down |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_ref | input | 1 | Asynchronous sync reference |
| align_sel | input | 1 | 1: pin request, 0: register request |
| align_pin | input | 1 | Realignment request, pin source |
| align_reg | input | 1 | Realignment request, register source |
| edge_pol | input | 1 | 0: rising reference edge, 1: falling |
| div_val | input | DIV_W (20) | Requested divide ratio |
| div_valid | input | 1 | Ratio strobe used while armed |
| skew | input | SKEW_W (17) | Cycles from reference edge to output pulse |
| fs_out | output | 1 | Frame sync pulse |

## Verification
The hardest behaviour to show from the ports is that something did not happen: an ignored reference edge, an ignored request source, or a ratio that is held off. In each of these cases the output simply keeps its old phase. The stimulus first locks onto a known pulse. It then opens a window of predicted pulse cycles that continue the old phase and applies the ignored stimulus inside that window. A missing, early or extra pulse shows up as a mismatch. The held-off ratio needs the block left armed with no usable edge. The bench therefore arms it while the reference sits at the level that the selected polarity does not treat as an edge.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

   typedef enum logic {
      SRC_REGISTER = 1'b0,
      SRC_PIN      = 1'b1
   } realign_src_e;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } ref_edge_e;

   // Legal ratio: unity, or even between 2 and max_v
   function automatic logic ratio_legal(input logic [31:0] v, input logic [31:0] max_v);
      return (v == 32'd1) || ((v >= 32'd2) && !v[0] && (v <= max_v));
   endfunction

endpackage

// File: rtl/fsd_ref_edge.sv
module fsd_ref_edge
   import fsd_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   input  logic pol,
   output logic edge_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              cur;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[0], ref_in};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], ref_in};
         end
      end
   endgenerate

   assign cur = chain_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   always_comb begin
      if (ref_edge_e'(pol) == EDGE_FALL) edge_o = prev_q & ~cur;
      else                               edge_o = cur & ~prev_q;
   end

endmodule

// File: rtl/fsd_ratio_reg.sv
module fsd_ratio_reg
   import fsd_pkg::*;
#(
   parameter int DIV_W   = 20,
   parameter int MAX_DIV = 524288,
   parameter int DEF_DIV = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gated,
   input  logic             strobe,
   input  logic [DIV_W-1:0] ratio_in,
   output logic [DIV_W-1:0] ratio_o
);

   localparam logic [31:0] MAX_U = 32'(MAX_DIV);

   logic take;
   logic ok;

   assign ok   = ratio_legal(32'(ratio_in), MAX_U);
   assign take = (gated ? strobe : 1'b1) & ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ratio_o <= DIV_W'(DEF_DIV);
      else if (take) ratio_o <= ratio_in;
   end

endmodule

// File: rtl/fsd_phase_cnt.sv
module fsd_phase_cnt #(
   parameter int DIV_W  = 20,
   parameter int SKEW_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  ratio,
   input  logic              load,
   input  logic [SKEW_W-1:0] skew,
   output logic [DIV_W-1:0]  cnt_o,
   output logic              tc_o
);

   logic [DIV_W-1:0] last;
   logic [DIV_W-1:0] skew_ext;
   logic [DIV_W-1:0] skew_eff;
   logic [DIV_W-1:0] load_val;

   assign last     = ratio - DIV_W'(1);
   assign skew_ext = DIV_W'(skew);
   assign skew_eff = (skew_ext > last) ? last : skew_ext;
   assign load_val = last - skew_eff;
   assign tc_o     = (cnt_o == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_o <= '0;
      else if (load)          cnt_o <= load_val;
      else if (cnt_o >= last) cnt_o <= '0;
      else                    cnt_o <= cnt_o + DIV_W'(1);
   end

endmodule

// File: rtl/fsd_frame_sync.sv
module fsd_frame_sync
   import fsd_pkg::*;
#(
   parameter int DIV_W       = 20,
   parameter int MAX_DIV     = 524288,
   parameter int DEF_DIV     = 8,
   parameter int SKEW_W      = 17,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_ref,
   input  logic              align_sel,
   input  logic              align_pin,
   input  logic              align_reg,
   input  logic              edge_pol,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              div_valid,
   input  logic [SKEW_W-1:0] skew,
   output logic              fs_out
);

   generate
      if (DIV_W < 2 || DIV_W > 31) begin : g_bad_width
         $error("DIV_W out of range");
      end
      if (MAX_DIV < 2 || MAX_DIV >= (1 << DIV_W) || (MAX_DIV % 2) != 0) begin : g_bad_max
         $error("MAX_DIV must be even and fit DIV_W");
      end
      if (!(DEF_DIV == 1 || (DEF_DIV >= 2 && (DEF_DIV % 2) == 0 && DEF_DIV <= MAX_DIV))) begin : g_bad_def
         $error("DEF_DIV is not a legal ratio");
      end
      if (SKEW_W < 1 || SKEW_W > DIV_W) begin : g_bad_skew
         $error("SKEW_W must not exceed DIV_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES below 2");
      end
   endgenerate

   logic             req_now;
   logic             req_q;
   logic             req_rise;
   logic             armed_q;
   logic             ref_edge;
   logic             load;
   logic [DIV_W-1:0] ratio_q;
   logic [DIV_W-1:0] cnt_q;

   assign req_now  = (realign_src_e'(align_sel) == SRC_PIN) ? align_pin : align_reg;
   assign req_rise = req_now & ~req_q;
   assign load     = armed_q & ref_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         armed_q <= 1'b1;
      end else begin
         req_q <= req_now;
         if (load)          armed_q <= 1'b0;
         else if (req_rise) armed_q <= 1'b1;
      end
   end

   fsd_ref_edge #(
      .STAGES (SYNC_STAGES)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_in (sync_ref),
      .pol    (edge_pol),
      .edge_o (ref_edge)
   );

   fsd_ratio_reg #(
      .DIV_W   (DIV_W),
      .MAX_DIV (MAX_DIV),
      .DEF_DIV (DEF_DIV)
   ) u_ratio (
      .clk      (clk),
      .rst_n    (rst_n),
      .gated    (armed_q),
      .strobe   (div_valid),
      .ratio_in (div_val),
      .ratio_o  (ratio_q)
   );

   fsd_phase_cnt #(
      .DIV_W  (DIV_W),
      .SKEW_W (SKEW_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .ratio (ratio_q),
      .load  (load),
      .skew  (skew),
      .cnt_o (cnt_q),
      .tc_o  (fs_out)
   );

endmodule

// File: rtl/fsd_frame_sync_chk.sv
module fsd_frame_sync_chk #(
   parameter int DIV_W   = 20,
   parameter int MAX_DIV = 524288
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fs_out,
   input logic             armed,
   input logic             load,
   input logic [DIV_W-1:0] ratio,
   input logic [DIV_W-1:0] cnt,
   input logic             div_valid
);

   // R1
   ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio == DIV_W'(1)) || (!ratio[0] && ratio >= DIV_W'(2) && ratio <= DIV_W'(MAX_DIV)));

   // R3
   unity_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio == DIV_W'(1)) |-> fs_out);

   // R2
   wrap_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_out && !load) |=> (cnt == '0));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && (cnt < ratio - DIV_W'(1))) |=> (cnt == $past(cnt) + DIV_W'(1)));

   // R9
   holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !div_valid) |=> $stable(ratio));

   // R10
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !armed);

endmodule

bind fsd_frame_sync fsd_frame_sync_chk #(
   .DIV_W   (DIV_W),
   .MAX_DIV (MAX_DIV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fs_out    (fs_out),
   .armed     (armed_q),
   .load      (load),
   .ratio     (ratio_q),
   .cnt       (cnt_q),
   .div_valid (div_valid)
);

// File: tb/sim_fsd_frame_sync.sv
`timescale 1ns/1ps
module sim_fsd_frame_sync;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_ref = 1'b0;
   logic        align_sel = 1'b0;
   logic        align_pin = 1'b0;
   logic        align_reg = 1'b0;
   logic        edge_pol = 1'b0;
   logic [19:0] div_val = 20'd8;
   logic        div_valid = 1'b0;
   logic [16:0] skew = '0;
   logic        fs_out;

   int    cyc = 0;
   int    checks = 0;
   int    fails = 0;
   int    exp_q[$];
   int    win_lo = 0;
   int    win_hi = -1;
   string cur_req = "";
   bit    done = 1'b0;

   fsd_frame_sync u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_ref  (sync_ref),
      .align_sel (align_sel),
      .align_pin (align_pin),
      .align_reg (align_reg),
      .edge_pol  (edge_pol),
      .div_val   (div_val),
      .div_valid (div_valid),
      .skew      (skew),
      .fs_out    (fs_out)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: pops predicted pulse cycles and compares
   always @(negedge clk) begin
      if (cyc >= win_lo && cyc <= win_hi && fs_out === 1'b1) begin
         int e;
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s: pulse at cycle %0d, expected none", cur_req, cyc);
         end else begin
            e = exp_q.pop_front();
            if (e != cyc) begin
               fails++;
               $display("FAIL %s: pulse at cycle %0d, expected %0d", cur_req, cyc, e);
            end
         end
      end
   end

   task automatic open_window(int base, int n, int lo, int hi, string r);
      cur_req = r;
      exp_q.delete();
      for (int t = base; t <= hi; t += n)
         if (t >= lo) exp_q.push_back(t);
      win_lo = lo;
      win_hi = hi;
   endtask

   task automatic close_window();
      while (cyc <= win_hi) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL %s: no pulse, expected at cycle %0d", cur_req, exp_q[0]);
      end
      win_hi = -1;
   endtask

   task automatic wait_pulse(output int p);
      do @(negedge clk); while (fs_out !== 1'b1);
      p = cyc;
   endtask

   task automatic pulse_req(bit pin);
      @(negedge clk);
      if (pin) align_pin = 1'b1; else align_reg = 1'b1;
      @(negedge clk);
      align_pin = 1'b0;
      align_reg = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic edge_and_check(logic v, int sk_eff, int n, string r);
      int m;
      @(negedge clk);
      sync_ref = v;
      m = cyc;
      open_window(m + 3 + sk_eff, n, m + 3, m + 3 + 4 * n, r);
      close_window();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int p;
      repeat (3) @(negedge clk);
      checks++;
      if (fs_out !== 1'b0) begin
         fails++;
         $display("FAIL R6: fs_out in reset %b, expected 0", fs_out);
      end
      rst_n = 1'b1;
      repeat (20) @(negedge clk);

      // R6 R7: armed from reset, rising edge, skew 2
      skew = 17'd2;
      edge_and_check(1'b1, 2, 8, "R6/R7");

      // R10: later edges do not move the phase
      wait_pulse(p);
      open_window(p, 8, p + 1, p + 60, "R10");
      repeat (3) @(negedge clk);
      sync_ref = 1'b0;
      repeat (6) @(negedge clk);
      sync_ref = 1'b1;
      close_window();

      // R4: register source selected, pin request ignored
      wait_pulse(p);
      open_window(p, 8, p + 1, p + 60, "R4");
      @(negedge clk);
      sync_ref = 1'b0;
      pulse_req(1'b1);
      sync_ref = 1'b1;
      close_window();
      @(negedge clk);
      sync_ref = 1'b0;
      pulse_req(1'b0);
      skew = 17'd0;
      edge_and_check(1'b1, 0, 8, "R4");

      // R4: pin source selected, register request ignored
      align_sel = 1'b1;
      wait_pulse(p);
      open_window(p, 8, p + 1, p + 60, "R4");
      @(negedge clk);
      sync_ref = 1'b0;
      pulse_req(1'b0);
      sync_ref = 1'b1;
      close_window();
      @(negedge clk);
      sync_ref = 1'b0;
      pulse_req(1'b1);
      skew = 17'd1;
      edge_and_check(1'b1, 1, 8, "R4");

      // R5: falling polarity, rising edge ignored
      align_sel = 1'b0;
      edge_pol  = 1'b1;
      @(negedge clk);
      sync_ref = 1'b0;
      repeat (4) @(negedge clk);
      pulse_req(1'b0);
      wait_pulse(p);
      open_window(p, 8, p + 1, p + 40, "R5");
      @(negedge clk);
      sync_ref = 1'b1;
      close_window();
      skew = 17'd4;
      edge_and_check(1'b0, 4, 8, "R5");

      // R8: skew beyond ratio acts as N-1
      @(negedge clk);
      sync_ref = 1'b1;
      repeat (4) @(negedge clk);
      pulse_req(1'b0);
      skew = 17'd20;
      edge_and_check(1'b0, 7, 8, "R8");

      // R9: armed, ratio held until strobe
      @(negedge clk);
      sync_ref = 1'b1;
      repeat (4) @(negedge clk);
      pulse_req(1'b0);
      wait_pulse(p);
      div_val = 20'd12;
      open_window(p, 8, p + 1, p + 40, "R9");
      close_window();
      wait_pulse(p);
      div_valid = 1'b1;
      open_window(p, 12, p + 1, p + 49, "R9");
      @(negedge clk);
      div_valid = 1'b0;
      close_window();
      skew = 17'd0;
      edge_and_check(1'b0, 0, 12, "R9");

      // R1: illegal ratios ignored
      wait_pulse(p);
      div_val = 20'd7;
      open_window(p, 12, p + 1, p + 49, "R1");
      close_window();
      wait_pulse(p);
      div_val = 20'd524290;
      open_window(p, 12, p + 1, p + 49, "R1");
      close_window();

      // R1 R2: smallest even ratio
      wait_pulse(p);
      div_val = 20'd2;
      open_window(p, 2, p + 1, p + 20, "R1/R2");
      close_window();

      // R3: unity ratio
      wait_pulse(p);
      div_val = 20'd1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         checks++;
         if (fs_out !== 1'b1) begin
            fails++;
            $display("FAIL R3: fs_out %b at cycle %0d, expected 1", fs_out, cyc);
         end
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule